// File: doc/BRIEF.md
# Power-Fail Guarded Byte Memory Controller

This block sits between an asynchronous memory-style bus (active-low select, output-enable and write-enable strobes, an address, and a byte-wide data path split into input, output and output-enable) and a small byte array. The three strobes and a digital supply-good indication are brought into the system clock domain through synchronizer chains. From them the block decodes one of three bus modes: idle, read or write. A write lands in the array on the cycle where the combined write condition (select low and write-enable low) ends. That can be the rise of either strobe, whichever comes first.

While the supply-good input is low, the block refuses all bus activity. It never drives the data path and never writes the array. A write that is still open when supply-good drops is abandoned.

Each time supply-good returns, the block samples a battery-health input. If the battery was reported weak, a sticky flag is armed. The flag swallows exactly one later write and then clears itself. Software can therefore probe battery health by writing the complement of a byte and reading it back.

Top module: `bbram_access_guard`

## Requirements
- R1: With select high (after synchronization), the data output enable is low and no write reaches the array, whatever the other strobes do.
- R2: With select low, output-enable low and write-enable high, the block drives the byte stored at the present address. The drive begins within three clock cycles of the strobes settling.
- R3: With select low and write-enable high but output-enable high, the data output enable stays low.
- R4: A write stores the captured byte at the captured address when the write condition ends. The end may come from write-enable rising or from select rising, and output-enable has no influence on the write.
- R5: Write-enable low with select low keeps the data output enable low, even if output-enable is low.
- R6: While supply-good is low, the data output enable is low and no strobe pattern changes any array byte.
- R7: When supply-good returns with the battery-health input low (weak battery), the next completed write is discarded and the addressed byte keeps its old value.
- R8: After one write has been discarded, later writes succeed. A power return with the battery-health input high (good battery) discards no write.
- R9: A write that is still open when supply-good falls is abandoned, and the addressed byte keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_n | input | 1 | Active-low chip select strobe (asynchronous) |
| rd_en_n | input | 1 | Active-low output-enable strobe (asynchronous) |
| wr_en_n | input | 1 | Active-low write-enable strobe (asynchronous) |
| addr | input | AW (8) | Byte address |
| dq_i | input | DW (8) | Write data from the bus |
| dq_o | output | DW (8) | Read data to the bus (zero when not driven) |
| dq_oe | output | 1 | High when the block drives the data bus |
| pwr_good | input | 1 | Supply-in-tolerance indication from the comparator |
| batt_ok | input | 1 | Battery-health status, sampled when supply-good returns |

## Verification
The assertions assume the strobes and supply-good change no faster than the two-stage synchronizers can follow. They also assume that address and write data stay stable from the start of a write until three cycles after its strobes rise, because both are captured on every cycle where the synchronized write condition holds. The bench keeps to these assumptions. Each task moves the strobes on a falling clock edge, holds them for four cycles, and then holds address and data for four more cycles. Supply-good is changed only while select is high, except in the scenario that deliberately cuts power mid-write.

// File: rtl/bbg_pkg.sv
package bbg_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/bbg_sync.sv
module bbg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bbg_decode.sv
module bbg_decode
  import bbg_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          pg_s,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          drive_en,
  output logic          commit,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  bus_mode_e     mode;
  logic          wr_now;
  logic          wr_prev_q, wr_prev_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  // Mode decode; an out-of-tolerance supply forces idle.
  always_comb begin
    mode = MODE_IDLE;
    if (pg_s && !sel_s) begin
      if (!wr_s)      mode = MODE_WRITE;
      else if (!rd_s) mode = MODE_READ;
    end
  end

  assign wr_now = (mode == MODE_WRITE);

  always_comb begin
    wr_prev_d = wr_now;
    addr_d    = addr_q;
    data_d    = data_q;
    if (wr_now) begin
      addr_d = addr;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      wr_prev_q <= wr_prev_d;
      addr_q    <= addr_d;
      data_q    <= data_d;
    end
  end

  // Write condition ended this cycle while supply is still good.
  assign commit   = wr_prev_q && !wr_now && pg_s;
  assign drive_en = (mode == MODE_READ);
  assign cap_addr = addr_q;
  assign cap_data = data_q;
endmodule

// File: rtl/bbg_batt_guard.sv
module bbg_batt_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic batt_ok,
  input  logic commit,
  output logic mem_we,
  output logic bad_flag
);
  logic pg_d_q;
  logic flag_q, flag_d;
  logic pg_rise;

  assign pg_rise = pg_s && !pg_d_q;

  always_comb begin
    flag_d = flag_q;
    if (pg_rise)     flag_d = !batt_ok;
    else if (commit) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pg_d_q <= pg_s;
      flag_q <= flag_d;
    end
  end

  assign mem_we   = commit && !flag_q;
  assign bad_flag = flag_q;
endmodule

// File: rtl/bbg_store.sv
module bbg_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bbram_access_guard.sv
module bbram_access_guard #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rd_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  input  logic          pwr_good,
  input  logic          batt_ok
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1110;

  logic [NSYNC-1:0] raw_v, syn_v;
  logic             sel_s, rd_s, wr_s, pg_s;
  logic             drive_en, commit, mem_we, bad_flag;
  logic [AW-1:0]    cap_addr;
  logic [DW-1:0]    cap_data, rdata;

  assign raw_v = {sel_n, rd_en_n, wr_en_n, pwr_good};

  bbg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
  );

  assign {sel_s, rd_s, wr_s, pg_s} = syn_v;

  bbg_decode #(.AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .rd_s(rd_s), .wr_s(wr_s),
    .pg_s(pg_s), .addr(addr), .din(dq_i), .drive_en(drive_en),
    .commit(commit), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  bbg_batt_guard u_guard (
    .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .batt_ok(batt_ok),
    .commit(commit), .mem_we(mem_we), .bad_flag(bad_flag)
  );

  bbg_store #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(cap_addr), .wdata(cap_data),
    .raddr(addr), .rdata(rdata)
  );

  assign dq_oe = drive_en;
  assign dq_o  = drive_en ? rdata : '0;
endmodule

// File: rtl/bbg_checker.sv
module bbg_checker (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic rd_en_n,
  input logic wr_en_n,
  input logic pwr_good,
  input logic batt_ok,
  input logic dq_oe,
  input logic pg_s,
  input logic commit,
  input logic mem_we,
  input logic bad_flag
);
  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n, 2) |-> !dq_oe);

  assert_oe_high_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en_n, 2) |-> !dq_oe);

  assert_write_blocks_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_n, 2) |-> !dq_oe);

  assert_powerfail_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_good, 2) |-> !dq_oe);

  assert_powerfail_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> pg_s);

  assert_weak_batt_drops_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_flag && commit) |-> !mem_we);

  assert_flag_set_by_weak_batt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_flag) |-> $past(!batt_ok));

  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_flag && commit && pg_s && $past(pg_s)) |=> !bad_flag);
endmodule

bind bbram_access_guard bbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n),
  .wr_en_n(wr_en_n), .pwr_good(pwr_good), .batt_ok(batt_ok),
  .dq_oe(dq_oe), .pg_s(pg_s), .commit(commit), .mem_we(mem_we),
  .bad_flag(bad_flag)
);

// File: tb/sim_bbram_access_guard.sv
`timescale 1ns/1ps
module sim_bbram_access_guard;
  logic       clk;
  logic       rst_n;
  logic       sel_n, rd_en_n, wr_en_n;
  logic [7:0] addr, dq_i, dq_o;
  logic       dq_oe, pwr_good, batt_ok;
  int         n_chk;
  int         n_bad;
  bit         timed_out;

  bbram_access_guard u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_en_n(rd_en_n),
    .wr_en_n(wr_en_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .pwr_good(pwr_good), .batt_ok(batt_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_bus();
    sel_n = 1'b1; rd_en_n = 1'b1; wr_en_n = 1'b1;
  endtask

  // write-enable controlled write; optional output-enable low
  task automatic wr_byte(logic [7:0] a, logic [7:0] d, bit oe_low);
    @(negedge clk);
    addr = a; dq_i = d; rd_en_n = !oe_low; sel_n = 1'b0; wr_en_n = 1'b0;
    idle(4);
    if (oe_low) check("R5 no drive during write", {7'd0, dq_oe}, 8'd0);
    wr_en_n = 1'b1; rd_en_n = 1'b1;
    idle(4);
    sel_n = 1'b1;
    idle(4);
  endtask

  task automatic rd_byte(logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b1;
    idle(4);
    d = dq_o; oe = dq_oe;
    release_bus();
    idle(3);
  endtask

  task automatic power_cycle(bit batt);
    @(negedge clk);
    pwr_good = 1'b0;
    idle(5);
    batt_ok = batt;
    pwr_good = 1'b1;
    idle(5);
  endtask

  task automatic t_reset();
    check("R6 reset no drive", {7'd0, dq_oe}, 8'd0);
  endtask

  task automatic t_basic_rw();
    logic [7:0] d; logic oe;
    wr_byte(8'h10, 8'hA5, 1'b0);
    rd_byte(8'h10, d, oe);
    check("R2 read drives", {7'd0, oe}, 8'd1);
    check("R4 we-ended write data", d, 8'hA5);
    wr_byte(8'h11, 8'h3C, 1'b0);
    rd_byte(8'h11, d, oe);
    check("R4 second address", d, 8'h3C);
    rd_byte(8'h10, d, oe);
    check("R2 first address kept", d, 8'hA5);
  endtask

  task automatic t_oe_high();
    @(negedge clk);
    addr = 8'h10; sel_n = 1'b0; rd_en_n = 1'b1; wr_en_n = 1'b1;
    idle(4);
    check("R3 oe high no drive", {7'd0, dq_oe}, 8'd0);
    release_bus();
    idle(3);
  endtask

  task automatic t_deselect();
    logic [7:0] d; logic oe;
    @(negedge clk);
    addr = 8'h10; sel_n = 1'b1; rd_en_n = 1'b0; wr_en_n = 1'b1;
    idle(4);
    check("R1 deselect no drive", {7'd0, dq_oe}, 8'd0);
    dq_i = 8'h00; wr_en_n = 1'b0;
    idle(4);
    wr_en_n = 1'b1;
    idle(4);
    release_bus();
    idle(3);
    rd_byte(8'h10, d, oe);
    check("R1 deselect no write", d, 8'hA5);
  endtask

  task automatic t_write_oe_low();
    logic [7:0] d; logic oe;
    wr_byte(8'h20, 8'h5A, 1'b1);
    rd_byte(8'h20, d, oe);
    check("R4 write with oe low", d, 8'h5A);
  endtask

  task automatic t_sel_ended();
    logic [7:0] d; logic oe;
    @(negedge clk);
    addr = 8'h21; dq_i = 8'hC3; wr_en_n = 1'b0;
    idle(2);
    sel_n = 1'b0;
    idle(4);
    sel_n = 1'b1;
    idle(4);
    wr_en_n = 1'b1;
    idle(4);
    rd_byte(8'h21, d, oe);
    check("R4 select-ended write", d, 8'hC3);
  endtask

  task automatic t_power_low();
    logic [7:0] d; logic oe;
    @(negedge clk);
    pwr_good = 1'b0;
    idle(4);
    addr = 8'h10; sel_n = 1'b0; rd_en_n = 1'b0; wr_en_n = 1'b1;
    idle(4);
    check("R6 power low no drive", {7'd0, dq_oe}, 8'd0);
    dq_i = 8'h77; wr_en_n = 1'b0;
    idle(4);
    wr_en_n = 1'b1;
    idle(4);
    release_bus();
    idle(4);
    batt_ok = 1'b1; pwr_good = 1'b1;
    idle(5);
    rd_byte(8'h10, d, oe);
    check("R6 power low no write", d, 8'hA5);
  endtask

  task automatic t_weak_batt();
    logic [7:0] d; logic oe;
    power_cycle(1'b0);
    rd_byte(8'h11, d, oe);
    check("R7 byte before probe", d, 8'h3C);
    wr_byte(8'h11, 8'hC3, 1'b0);
    rd_byte(8'h11, d, oe);
    check("R7 first write discarded", d, 8'h3C);
    wr_byte(8'h11, 8'hC3, 1'b0);
    rd_byte(8'h11, d, oe);
    check("R8 second write lands", d, 8'hC3);
    power_cycle(1'b1);
    wr_byte(8'h11, 8'h96, 1'b0);
    rd_byte(8'h11, d, oe);
    check("R8 good battery no discard", d, 8'h96);
  endtask

  task automatic t_abandon();
    logic [7:0] d; logic oe;
    @(negedge clk);
    addr = 8'h20; dq_i = 8'hFF; sel_n = 1'b0; wr_en_n = 1'b0;
    idle(4);
    pwr_good = 1'b0;
    idle(4);
    release_bus();
    idle(4);
    batt_ok = 1'b1; pwr_good = 1'b1;
    idle(5);
    rd_byte(8'h20, d, oe);
    check("R9 interrupted write abandoned", d, 8'h5A);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; timed_out = 1'b0;
    rst_n = 1'b0; release_bus(); addr = '0; dq_i = '0;
    pwr_good = 1'b0; batt_ok = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    pwr_good = 1'b1;
    idle(5);
    t_basic_rw();
    t_oe_high();
    t_deselect();
    t_write_oe_low();
    t_sel_ended();
    t_power_low();
    t_weak_batt();
    t_abandon();
    finish_run();
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    timed_out = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule